// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a three-and-a-half digit integrating converter. It divides the oscillator clock into a slower count rate. On that rate it repeats a fixed sequence of three phases without end. First the integrator is zeroed. Next the unknown input is integrated for a fixed 1000 counts. Last the reference is integrated back towards zero, and this phase is timed in decimal counts.

The sequencer drives the switch controls for the analog front end. One of these selects the polarity of the reference, opposite to the input. It also exports a status flag for the integrate phase and another for the de-integrate phase. When de-integration ends, the count, the sign and an overrange mark move into an output register that feeds a display decoder. A hold input stops that register from updating, but the conversions keep running underneath.

The comparator and hold inputs are expected to be synchronous to the clock. The reset is asserted asynchronously and must be released in step with the clock. The auto-zero length is set by a parameter (1 to 2000 counts).

Top module: `dsadc_top`

## Requirements
- R1: The phases follow the order auto-zero, integrate, de-integrate, then back to auto-zero. Exactly one of the auto-zero switch, the input switch and the de-integrate flag is high at any time. Auto-zero lasts AZ_COUNTS × CLK_DIV clocks.
- R2: One count equals CLK_DIV (default 4) clocks. The input switch and the integrate flag are both high for exactly 1000 counts, which is 4000 clocks at the default.
- R3: The de-integrate flag is high for the whole de-integrate phase. The phase ends at the first count boundary where the comparator no longer matches the sign taken at the end of integration. If the comparator flips after N counts, the phase lasts (N+1) × CLK_DIV clocks and the reading is N.
- R4: The reading is held as a thousands bit (rd_thou_o) plus three BCD decades: hundreds, tens and units, each 4 bits. The output register changes only at the clock edge that ends de-integration.
- R5: While hold_i is high at the end of de-integration, the output register keeps its previous value. The phase sequence continues unchanged.
- R6: The sign is taken from the comparator at the last count of integration. A low comparator (input negative) sets rd_neg_o = 1. This also holds for a reading of zero.
- R7: During de-integration exactly one reference switch is closed. refn_sw_o is closed for a positive input and refp_sw_o for a negative input. Both are open in the other phases.
- R8: If 2000 counts pass without a crossing, de-integration ends after 2000 × CLK_DIV clocks. The register then takes rd_ovr_o = 1 and digits 1999. rd_ovr_o = 0 for a normal reading.
- R9: During reset the phase is auto-zero, both status flags and both reference switches are low, and the output register is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | oscillator clock |
| rst_ni | input | 1 | active-low reset |
| cmp_i | input | 1 | comparator, high when the integrator holds positive charge |
| hold_i | input | 1 | freeze the output register |
| az_sw_o | output | 1 | auto-zero switch control |
| in_sw_o | output | 1 | input switch control |
| refp_sw_o | output | 1 | positive reference switch control |
| refn_sw_o | output | 1 | negative reference switch control |
| int_flag_o | output | 1 | integrate phase status |
| deint_flag_o | output | 1 | de-integrate phase status |
| rd_thou_o | output | 1 | reading, thousands bit |
| rd_hund_o | output | 4 | reading, hundreds BCD |
| rd_tens_o | output | 4 | reading, tens BCD |
| rd_unit_o | output | 4 | reading, units BCD |
| rd_neg_o | output | 1 | reading sign, high for negative |
| rd_ovr_o | output | 1 | overrange mark |

## Verification
The comparator model flips after a chosen number of de-integration counts. Directed values are 0, 999, 1000 and 1999. The 999 and 1000 cases separate carries within the three decades from the carry into the thousands bit. Zero with a negative input shows that the sign is kept at a null reading. A run with no flip at all tells a proper overrange stop from a silent wrap. Random counts with a random sign and hold, plus one directed held conversion, show that hold freezes only the result while the phase lengths stay the same.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

  localparam int NDEC      = 3;
  localparam int DIG_W     = 4;
  localparam int CNT_W     = NDEC * DIG_W + 1;
  localparam int DEC_SPAN  = 10 ** NDEC;
  localparam int MAX_COUNT = 2 * DEC_SPAN;

  typedef enum logic [1:0] {
    PH_AZ    = 2'd0,
    PH_INT   = 2'd1,
    PH_DEINT = 2'd2
  } phase_e;

  typedef struct packed {
    logic             ovr;
    logic             neg;
    logic [CNT_W-1:0] cnt;
  } reading_t;

  // Binary to counter code: thousands bit on top, then BCD decades.
  function automatic logic [CNT_W-1:0] bcd_of(input int v);
    logic [CNT_W-1:0] r;
    int rem;
    r   = '0;
    rem = v;
    if (rem >= DEC_SPAN) begin
      r[CNT_W-1] = 1'b1;
      rem        = rem - DEC_SPAN;
    end
    for (int d = 0; d < NDEC; d++) begin
      r[d*DIG_W +: DIG_W] = DIG_W'(rem % 10);
      rem                 = rem / 10;
    end
    return r;
  endfunction

endpackage

// File: rtl/dsadc_prescaler.sv
module dsadc_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/dsadc_bcd_counter.sv
module dsadc_bcd_counter
  import dsadc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] value_o
);
  logic [NDEC-1:0] nine;
  logic            thou_q, thou_d;

  for (genvar i = 0; i < NDEC; i++) begin : g_dec
    localparam logic [NDEC-1:0] LOW_MASK = NDEC'((1 << i) - 1);
    logic [DIG_W-1:0] dig_q, dig_d;
    logic             cin;

    assign cin     = inc_i && ((nine & LOW_MASK) == LOW_MASK);
    assign nine[i] = (dig_q == DIG_W'(9));

    always_comb begin
      dig_d = dig_q;
      if (clr_i)    dig_d = '0;
      else if (cin) dig_d = nine[i] ? '0 : dig_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dig_q <= '0;
      else         dig_q <= dig_d;
    end

    assign value_o[i*DIG_W +: DIG_W] = dig_q;
  end

  always_comb begin
    thou_d = thou_q;
    if (clr_i)                   thou_d = 1'b0;
    else if (inc_i && (&nine))   thou_d = ~thou_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) thou_q <= 1'b0;
    else         thou_q <= thou_d;
  end

  assign value_o[CNT_W-1] = thou_q;
endmodule

// File: rtl/dsadc_sequencer.sv
module dsadc_sequencer
  import dsadc_pkg::*;
#(
  parameter int AZ_COUNTS  = 1000,
  parameter int INT_COUNTS = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cmp_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             cnt_clr_o,
  output logic             cnt_inc_o,
  output phase_e           phase_o,
  output logic             neg_o,
  output logic             load_o,
  output logic             ovr_o
);
  localparam logic [CNT_W-1:0] AZ_LAST   = bcd_of(AZ_COUNTS - 1);
  localparam logic [CNT_W-1:0] INT_LAST  = bcd_of(INT_COUNTS - 1);
  localparam logic [CNT_W-1:0] FULL_LAST = bcd_of(MAX_COUNT - 1);

  phase_e phase_q, phase_d;
  logic   neg_q, neg_d;

  always_comb begin
    phase_d   = phase_q;
    neg_d     = neg_q;
    cnt_clr_o = 1'b0;
    cnt_inc_o = 1'b0;
    load_o    = 1'b0;
    ovr_o     = 1'b0;
    if (tick_i) begin
      unique case (phase_q)
        PH_AZ: begin
          if (cnt_i == AZ_LAST) begin
            phase_d   = PH_INT;
            cnt_clr_o = 1'b1;
          end else begin
            cnt_inc_o = 1'b1;
          end
        end
        PH_INT: begin
          if (cnt_i == INT_LAST) begin
            phase_d   = PH_DEINT;
            cnt_clr_o = 1'b1;
            neg_d     = ~cmp_i;
          end else begin
            cnt_inc_o = 1'b1;
          end
        end
        PH_DEINT: begin
          if (cmp_i == neg_q) begin
            phase_d   = PH_AZ;
            cnt_clr_o = 1'b1;
            load_o    = 1'b1;
          end else if (cnt_i == FULL_LAST) begin
            phase_d   = PH_AZ;
            cnt_clr_o = 1'b1;
            load_o    = 1'b1;
            ovr_o     = 1'b1;
          end else begin
            cnt_inc_o = 1'b1;
          end
        end
        default: begin
          phase_d   = PH_AZ;
          cnt_clr_o = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_AZ;
      neg_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      neg_q   <= neg_d;
    end
  end

  assign phase_o = phase_q;
  assign neg_o   = neg_q;
endmodule

// File: rtl/dsadc_result_reg.sv
module dsadc_result_reg
  import dsadc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  logic     hold_i,
  input  reading_t d_i,
  output reading_t q_o
);
  reading_t q_q, q_d;
  logic     en;

  assign en = load_i && !hold_i;

  always_comb begin
    q_d = q_q;
    if (en) q_d = d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/dsadc_top.sv
module dsadc_top
  import dsadc_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int AZ_COUNTS  = 1000,
  parameter int INT_COUNTS = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmp_i,
  input  logic       hold_i,
  output logic       az_sw_o,
  output logic       in_sw_o,
  output logic       refp_sw_o,
  output logic       refn_sw_o,
  output logic       int_flag_o,
  output logic       deint_flag_o,
  output logic       rd_thou_o,
  output logic [3:0] rd_hund_o,
  output logic [3:0] rd_tens_o,
  output logic [3:0] rd_unit_o,
  output logic       rd_neg_o,
  output logic       rd_ovr_o
);
  logic             tick, cnt_clr, cnt_inc, neg, load, ovr;
  logic [CNT_W-1:0] cnt;
  phase_e           phase;
  reading_t         rd_d, rd_q;

  dsadc_prescaler #(.DIV(CLK_DIV)) u_pre (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  dsadc_bcd_counter u_cnt (
    .clk_i  (clk_i), .rst_ni(rst_ni),
    .clr_i  (cnt_clr), .inc_i(cnt_inc), .value_o(cnt)
  );

  dsadc_sequencer #(.AZ_COUNTS(AZ_COUNTS), .INT_COUNTS(INT_COUNTS)) u_seq (
    .clk_i    (clk_i),   .rst_ni   (rst_ni), .tick_i(tick),
    .cmp_i    (cmp_i),   .cnt_i    (cnt),
    .cnt_clr_o(cnt_clr), .cnt_inc_o(cnt_inc),
    .phase_o  (phase),   .neg_o    (neg),
    .load_o   (load),    .ovr_o    (ovr)
  );

  assign rd_d = '{ovr: ovr, neg: neg, cnt: cnt};

  dsadc_result_reg u_res (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load),
    .hold_i(hold_i), .d_i(rd_d), .q_o(rd_q)
  );

  assign az_sw_o      = (phase == PH_AZ);
  assign in_sw_o      = (phase == PH_INT);
  assign int_flag_o   = (phase == PH_INT);
  assign deint_flag_o = (phase == PH_DEINT);
  assign refp_sw_o    = deint_flag_o &&  neg;
  assign refn_sw_o    = deint_flag_o && !neg;

  assign rd_thou_o = rd_q.cnt[CNT_W-1];
  assign rd_hund_o = rd_q.cnt[2*DIG_W +: DIG_W];
  assign rd_tens_o = rd_q.cnt[DIG_W +: DIG_W];
  assign rd_unit_o = rd_q.cnt[0 +: DIG_W];
  assign rd_neg_o  = rd_q.neg;
  assign rd_ovr_o  = rd_q.ovr;
endmodule

// File: rtl/dsadc_checker.sv
module dsadc_checker #(
  parameter int CLK_DIV    = 4,
  parameter int INT_COUNTS = 1000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmp_i,
  input logic       hold_i,
  input logic       az_sw_o,
  input logic       in_sw_o,
  input logic       refp_sw_o,
  input logic       refn_sw_o,
  input logic       int_flag_o,
  input logic       deint_flag_o,
  input logic       rd_thou_o,
  input logic [3:0] rd_hund_o,
  input logic [3:0] rd_tens_o,
  input logic [3:0] rd_unit_o,
  input logic       rd_neg_o,
  input logic       rd_ovr_o
);
  localparam int INT_CLKS = CLK_DIV * INT_COUNTS;
  localparam int MAX_CLKS = CLK_DIV * 2000;

  logic [14:0] rd_bus;
  logic [31:0] int_run_q, deint_run_q;
  logic        unused_cmp;

  assign rd_bus     = {rd_ovr_o, rd_neg_o, rd_thou_o, rd_hund_o, rd_tens_o, rd_unit_o};
  assign unused_cmp = cmp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_run_q   <= '0;
      deint_run_q <= '0;
    end else begin
      int_run_q   <= int_flag_o   ? int_run_q + 1   : '0;
      deint_run_q <= deint_flag_o ? deint_run_q + 1 : '0;
    end
  end

  AST_ONE_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({az_sw_o, in_sw_o, deint_flag_o}) == 1); // R1
  AST_AZ_BEFORE_INT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_flag_o) |-> $past(az_sw_o)); // R1
  AST_INT_BEFORE_DEINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(deint_flag_o) |-> $past(int_flag_o)); // R1
  AST_INT_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(int_flag_o) |-> (int_run_q == INT_CLKS)); // R2
  AST_DEINT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deint_flag_o |-> (deint_run_q < MAX_CLKS)); // R8
  AST_RD_ONLY_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rd_bus) |-> $fell(deint_flag_o)); // R4
  AST_HOLD_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rd_bus) |-> !$past(hold_i)); // R5
  AST_ONE_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deint_flag_o |-> (refp_sw_o ^ refn_sw_o)); // R7
  AST_REF_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !deint_flag_o |-> !(refp_sw_o || refn_sw_o)); // R7
  AST_REF_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deint_flag_o && $past(deint_flag_o)) |-> $stable(refp_sw_o)); // R7
  AST_OVR_DIGITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ovr_o |-> (rd_bus[12:0] == 13'h1999)); // R8
endmodule

bind dsadc_top dsadc_checker #(.CLK_DIV(CLK_DIV), .INT_COUNTS(INT_COUNTS)) u_chk (.*);

// File: tb/tb_dsadc_top.sv
module tb_dsadc_top;
  localparam int AZ = 200;

  logic       clk_i = 1'b0;
  logic       rst_ni, cmp_i, hold_i;
  logic       az_sw_o, in_sw_o, refp_sw_o, refn_sw_o, int_flag_o, deint_flag_o;
  logic       rd_thou_o, rd_neg_o, rd_ovr_o;
  logic [3:0] rd_hund_o, rd_tens_o, rd_unit_o;

  int n_run  = 0;
  int n_fail = 0;
  int exp_rd = 0;
  bit first  = 1'b1;

  always #4 clk_i = ~clk_i;

  dsadc_top #(.CLK_DIV(4), .AZ_COUNTS(AZ), .INT_COUNTS(1000)) dut (.*);

  task automatic chk(input string what, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int bcd13(input int v);
    int t = v / 1000;
    int r = v % 1000;
    return (t << 12) | ((r / 100) << 8) | (((r / 10) % 10) << 4) | (r % 10);
  endfunction

  function automatic int rd_now();
    return {17'd0, rd_ovr_o, rd_neg_o, rd_thou_o, rd_hund_o, rd_tens_o, rd_unit_o};
  endfunction

  // Starts at a negedge in auto-zero; ends at the first negedge of the next auto-zero.
  task automatic conv(input int n, input bit pos, input bit hold);
    int az_len = 0;
    int int_len = 0;
    int dl = 1;
    hold_i = hold;
    cmp_i  = pos;
    while (az_sw_o) begin az_len++; @(negedge clk_i); end
    if (!first) chk("R1 auto-zero length", az_len, AZ * 4);
    first = 1'b0;
    chk("R10 input switch in integrate", in_sw_o, 1);
    while (int_flag_o) begin int_len++; @(negedge clk_i); end
    chk("R2 integrate length", int_len, 4000);
    chk("R3 de-integrate flag", deint_flag_o, 1);
    chk("R7 negative reference for positive input", refn_sw_o, pos);
    chk("R7 positive reference for negative input", refp_sw_o, !pos);
    if (n < 2000) begin
      repeat (4 * n) begin @(negedge clk_i); if (deint_flag_o) dl++; end
      cmp_i = !pos;
      forever begin @(negedge clk_i); if (!deint_flag_o) break; dl++; end
      chk("R3 de-integrate length", dl, 4 * n + 4);
      if (!hold) exp_rd = ((!pos) << 13) | bcd13(n);
    end else begin
      forever begin @(negedge clk_i); if (!deint_flag_o) break; dl++; end
      chk("R8 overrange length", dl, 8000);
      if (!hold) exp_rd = (1 << 14) | ((!pos) << 13) | bcd13(1999);
    end
    chk(hold ? "R5 held reading" : "R4 R6 R8 reading", rd_now(), exp_rd);
  endtask

  initial begin
    void'($urandom(32'h5EED_0D11));
    rst_ni = 1'b0; cmp_i = 1'b0; hold_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R9 reset auto-zero", az_sw_o, 1);
    chk("R9 reset flags", {int_flag_o, deint_flag_o, refp_sw_o, refn_sw_o}, 0);
    chk("R9 reset reading", rd_now(), 0);
    rst_ni = 1'b1;
    conv(123, 1'b1, 1'b0);
    conv(0, 1'b0, 1'b0);     // R6 zero reading keeps the minus sign
    conv(999, 1'b1, 1'b0);   // R4 decade carries
    conv(1000, 1'b0, 1'b0);  // R4 carry into thousands
    conv(1999, 1'b1, 1'b0);  // R3 last count before overrange
    conv(2500, 1'b0, 1'b0);  // R8 no crossing
    conv(456, 1'b1, 1'b1);   // R5 hold keeps overrange reading
    for (int k = 0; k < 3; k++)
      conv($urandom_range(0, 1999), 1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0));
    conv(77, 1'b0, 1'b0);    // R5 update resumes after hold
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk_i);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule